// File: doc/BRIEF.md
# Cache-Line Copy Engine

This block copies a run of 512-bit cache lines from one region of memory to another. Software or a scheduler places an input base address, an output base address and a 32-bit line count on the configuration inputs, then raises `start`. The engine then drives four valid/ready channels toward a memory system: read requests, read responses, write requests and write data. Consecutive lines lie 64 bytes apart.

Three activities run side by side once a copy is under way. The read issuer walks the input addresses. The write issuer walks the output addresses. The forwarder hands each read response, in arrival order, straight to the write-data channel. Reads in flight are limited by a parameterised budget of response slots. A slot is taken when a read request is accepted and given back when its data has been accepted as write data. With a memory latency of L cycles, a budget of roughly L slots or more keeps one line per cycle moving. A smaller budget cuts throughput roughly in proportion.

`done` rises once every line has been forwarded and every write request accepted. It stays high for as long as `start` is held, and dropping `start` returns the engine to idle.

Top module: `clcopy_top`

## Requirements
- R1: While reset is asserted and right after it, `done`, `rdReqValid`, `wrReqValid`, `wrDataValid` and `rdRspReady` are all 0.
- R2: The base addresses and the line count are captured on the first clock edge where `start` is 1 in idle. Changes to them during a copy have no effect on addresses, data or line count.
- R3: Read requests carry addresses inBase + 64·k for k = 0, 1, … count−1, in ascending order, and each address appears exactly once.
- R4: Write requests carry addresses outBase + 64·k for k = 0 … count−1, in ascending order. Exactly count of them are accepted.
- R5: The k-th accepted write-data beat equals the k-th read response, which is the line read from inBase + 64·k. Responses are assumed to arrive in request order.
- R6: The number of reads accepted but not yet forwarded as write data never exceeds SLOTS. When memory latency exceeds the budget, that number reaches SLOTS.
- R7: `done` goes to 1 only after count write-data beats and count write requests have been accepted. It stays 1, with no requests valid, while `start` stays 1. It is 0 on the cycle after the first edge with `start` at 0.
- R8: A line count of 0 raises `done` on the cycle after start is captured. No read, write-request or write-data handshake takes place.
- R9: Under backpressure on any channel, no line is lost or duplicated. A request that is valid and not accepted stays valid with an unchanged address.
- R10: With a memory latency well below SLOTS and no backpressure, a copy of N lines finishes within N + 12 cycles of start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin copy; hold until done, then release |
| inBase | input | ADDR_W | Byte address of first source line |
| outBase | input | ADDR_W | Byte address of first destination line |
| lineCount | input | CNT_W | Number of lines to copy |
| done | output | 1 | Copy complete |
| rdReqValid | output | 1 | Read request valid |
| rdReqReady | input | 1 | Memory accepts read request |
| rdReqAddr | output | ADDR_W | Read request address |
| rdRspValid | input | 1 | Read response valid |
| rdRspReady | output | 1 | Engine accepts read response |
| rdRspData | input | WORD_W*WORDS | Read response line |
| wrReqValid | output | 1 | Write request valid |
| wrReqReady | input | 1 | Memory accepts write request |
| wrReqAddr | output | ADDR_W | Write request address |
| wrDataValid | output | 1 | Write data valid |
| wrDataReady | input | 1 | Memory accepts write data |
| wrData | output | WORD_W*WORDS | Write data line |

## Verification
Three events can land on the same edge: a slot being freed by a forwarded line, a new read being accepted, and the slot count sitting exactly at its limit. To force this, memory latency is made longer than the slot budget, so the read issuer stalls at the cap and restarts on the very edge where a response drains. Cyclic readiness patterns on the write-data and write-request channels then move that edge around. The bench keeps its own count of reads accepted minus lines forwarded, and requires it to peak at exactly SLOTS and never go beyond. The checks on address order and data content confirm that a read taken on the same edge as a release is neither lost nor issued twice.

// File: rtl/clcopy_pkg.sv
package clcopy_pkg;
  typedef struct packed {
    logic load;
    logic run;
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } copy_state_t;
endpackage

// File: rtl/clcopy_ctrl.sv
module clcopy_ctrl
  import clcopy_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         zeroLen,
  input  logic         finished,
  output ctrl_strobe_t strobe,
  output logic         done
);
  copy_state_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (start) nextState = zeroLen ? ST_DONE : ST_RUN;
      ST_RUN:  if (finished) nextState = ST_DONE;
      ST_DONE: if (!start) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign strobe.load = (state == ST_IDLE) && start;
  assign strobe.run  = (state == ST_RUN);
  assign done        = (state == ST_DONE);
endmodule

// File: rtl/clcopy_datapath.sv
module clcopy_datapath
  import clcopy_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 32,
  parameter int SLOTS  = 128,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] inBase,
  input  logic [ADDR_W-1:0] outBase,
  input  logic [CNT_W-1:0]  lineCount,
  output logic              zeroLen,
  output logic              finished,
  output logic              rdReqValid,
  input  logic              rdReqReady,
  output logic [ADDR_W-1:0] rdReqAddr,
  input  logic              rdRspValid,
  output logic              rdRspReady,
  input  logic [LINE_W-1:0] rdRspData,
  output logic              wrReqValid,
  input  logic              wrReqReady,
  output logic [ADDR_W-1:0] wrReqAddr,
  output logic              wrDataValid,
  input  logic              wrDataReady,
  output logic [LINE_W-1:0] wrData
);
  localparam int SLOT_W     = $clog2(SLOTS + 1);
  localparam int LINE_BYTES = LINE_W / 8;
  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(LINE_BYTES);
  localparam logic [SLOT_W-1:0] BUDGET = SLOT_W'(SLOTS);

  logic [CNT_W-1:0]  total, rdCnt, wrCnt, fwdCnt;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [SLOT_W-1:0] inFlight;
  logic              rdFire, wrFire, fwdFire;

  // read address generator
  assign rdReqValid = strobe.run && (rdCnt != total) && (inFlight != BUDGET);
  assign rdReqAddr  = rdAddr;
  assign rdFire     = rdReqValid && rdReqReady;

  // write address generator
  assign wrReqValid = strobe.run && (wrCnt != total);
  assign wrReqAddr  = wrAddr;
  assign wrFire     = wrReqValid && wrReqReady;

  // fetcher: response passes straight to write data
  assign wrDataValid = strobe.run && rdRspValid;
  assign rdRspReady  = strobe.run && wrDataReady;
  assign wrData      = rdRspData;
  assign fwdFire     = wrDataValid && wrDataReady;

  assign zeroLen  = (lineCount == '0);
  assign finished = (fwdCnt == total) && (wrCnt == total);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      total    <= '0;
      rdCnt    <= '0;
      wrCnt    <= '0;
      fwdCnt   <= '0;
      rdAddr   <= '0;
      wrAddr   <= '0;
      inFlight <= '0;
    end else if (strobe.load) begin
      total    <= lineCount;
      rdCnt    <= '0;
      wrCnt    <= '0;
      fwdCnt   <= '0;
      rdAddr   <= inBase;
      wrAddr   <= outBase;
      inFlight <= '0;
    end else begin
      if (rdFire) begin
        rdCnt  <= rdCnt + 1'b1;
        rdAddr <= rdAddr + STEP;
      end
      if (wrFire) begin
        wrCnt  <= wrCnt + 1'b1;
        wrAddr <= wrAddr + STEP;
      end
      if (fwdFire) fwdCnt <= fwdCnt + 1'b1;
      case ({rdFire, fwdFire})
        2'b10:   inFlight <= inFlight + 1'b1;
        2'b01:   inFlight <= inFlight - 1'b1;
        default: inFlight <= inFlight;
      endcase
    end
  end
endmodule

// File: rtl/clcopy_top.sv
module clcopy_top
  import clcopy_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 32,
  parameter int SLOTS  = 128,
  parameter int WORD_W = 64,
  parameter int WORDS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       inBase,
  input  logic [ADDR_W-1:0]       outBase,
  input  logic [CNT_W-1:0]        lineCount,
  output logic                    done,
  output logic                    rdReqValid,
  input  logic                    rdReqReady,
  output logic [ADDR_W-1:0]       rdReqAddr,
  input  logic                    rdRspValid,
  output logic                    rdRspReady,
  input  logic [WORD_W*WORDS-1:0] rdRspData,
  output logic                    wrReqValid,
  input  logic                    wrReqReady,
  output logic [ADDR_W-1:0]       wrReqAddr,
  output logic                    wrDataValid,
  input  logic                    wrDataReady,
  output logic [WORD_W*WORDS-1:0] wrData
);
  localparam int LINE_W = WORD_W * WORDS;

  ctrl_strobe_t strobe;
  logic         zeroLen, finished;

  clcopy_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .zeroLen(zeroLen),
    .finished(finished), .strobe(strobe), .done(done)
  );

  clcopy_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SLOTS(SLOTS), .LINE_W(LINE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inBase(inBase), .outBase(outBase), .lineCount(lineCount),
    .zeroLen(zeroLen), .finished(finished),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdRspValid(rdRspValid), .rdRspReady(rdRspReady), .rdRspData(rdRspData),
    .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .wrReqAddr(wrReqAddr),
    .wrDataValid(wrDataValid), .wrDataReady(wrDataReady), .wrData(wrData)
  );
endmodule

// File: rtl/clcopy_chk.sv
module clcopy_chk #(
  parameter int ADDR_W = 48,
  parameter int SLOTS  = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              rdReqValid,
  input logic              rdReqReady,
  input logic [ADDR_W-1:0] rdReqAddr,
  input logic              wrReqValid,
  input logic              wrReqReady,
  input logic [ADDR_W-1:0] wrReqAddr,
  input logic              wrDataValid,
  input logic              wrDataReady
);
  localparam int CW = $clog2(SLOTS + 1) + 1;
  logic [CW-1:0] outstanding;
  logic          rdTake, fwdTake;

  assign rdTake  = rdReqValid && rdReqReady;
  assign fwdTake = wrDataValid && wrDataReady;

  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= '0;
    else if (rdTake && !fwdTake) outstanding <= outstanding + 1'b1;
    else if (!rdTake && fwdTake) outstanding <= outstanding - 1'b1;
  end

  // R6
  slot_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= CW'(SLOTS));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqValid && !rdReqReady) |=> (rdReqValid && $stable(rdReqAddr)));

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrReqValid && !wrReqReady) |=> (wrReqValid && $stable(wrReqAddr)));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> done);

  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!rdReqValid && !wrReqValid && !wrDataValid));
endmodule

bind clcopy_top clcopy_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
  .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .wrReqAddr(wrReqAddr),
  .wrDataValid(wrDataValid), .wrDataReady(wrDataReady)
);

// File: tb/sim_clcopy_top.sv
`timescale 1ns/1ps
module sim_clcopy_top;
  localparam int AW = 48;
  localparam int CW = 32;
  localparam int NS = 4;
  localparam int LW = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] inBase = '0, outBase = '0;
  logic [CW-1:0] lineCount = '0;
  logic done;
  logic rdReqValid, rdReqReady = 1'b0;
  logic [AW-1:0] rdReqAddr;
  logic rdRspValid = 1'b0, rdRspReady;
  logic [LW-1:0] rdRspData = '0;
  logic wrReqValid, wrReqReady = 1'b0;
  logic [AW-1:0] wrReqAddr;
  logic wrDataValid, wrDataReady = 1'b0;
  logic [LW-1:0] wrData;

  always #5 clk = ~clk;

  clcopy_top #(.ADDR_W(AW), .CNT_W(CW), .SLOTS(NS)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inBase(inBase), .outBase(outBase),
    .lineCount(lineCount), .done(done),
    .rdReqValid(rdReqValid), .rdReqReady(rdReqReady), .rdReqAddr(rdReqAddr),
    .rdRspValid(rdRspValid), .rdRspReady(rdRspReady), .rdRspData(rdRspData),
    .wrReqValid(wrReqValid), .wrReqReady(wrReqReady), .wrReqAddr(wrReqAddr),
    .wrDataValid(wrDataValid), .wrDataReady(wrDataReady), .wrData(wrData)
  );

  function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
    logic [LW-1:0] v;
    for (int i = 0; i < 8; i++)
      v[i*64 +: 64] = {a, 16'h0} ^ (64'h9E37_79B9_7F4A_7C15 * 64'(i + 1));
    return v;
  endfunction

  // bench-side memory and monitors
  int            memLat = 2;
  int            rdyMode = 0;
  logic [AW-1:0] expIn = '0, expOut = '0;
  logic [AW-1:0] qa[$];
  int            qr[$];
  int cyc = 0;
  int rdIdx = 0, wrIdx = 0, datIdx = 0, inFl = 0, maxInFl = 0;
  int rdErrs = 0, wrErrs = 0, datErrs = 0, holdErrs = 0;
  logic          prevRdStall = 1'b0, prevWrStall = 1'b0;
  logic [AW-1:0] prevRdAddr = '0, prevWrAddr = '0;

  always @(negedge clk) begin
    cyc++;
    case (rdyMode)
      1: begin
        rdReqReady  <= (cyc % 7) != 0;
        wrReqReady  <= (cyc % 5) != 0;
        wrDataReady <= (cyc % 3) != 0;
      end
      2: begin
        rdReqReady  <= 1'b1;
        wrReqReady  <= (cyc % 8) == 0;
        wrDataReady <= 1'b1;
      end
      default: begin
        rdReqReady  <= 1'b1;
        wrReqReady  <= 1'b1;
        wrDataReady <= 1'b1;
      end
    endcase
    if (qa.size() > 0 && qr[0] <= cyc) begin
      rdRspValid <= 1'b1;
      rdRspData  <= pat(qa[0]);
    end else begin
      rdRspValid <= 1'b0;
    end
    #1;
    if (prevRdStall && !(rdReqValid && rdReqAddr == prevRdAddr)) holdErrs++;
    if (prevWrStall && !(wrReqValid && wrReqAddr == prevWrAddr)) holdErrs++;
    prevRdStall = rdReqValid && !rdReqReady;
    prevWrStall = wrReqValid && !wrReqReady;
    prevRdAddr  = rdReqAddr;
    prevWrAddr  = wrReqAddr;
    if (rdReqValid && rdReqReady) begin
      if (rdReqAddr != expIn + 64 * rdIdx) begin
        rdErrs++;
        $display("mismatch rd addr %h exp %h", rdReqAddr, expIn + 64 * rdIdx);
      end
      qa.push_back(rdReqAddr);
      qr.push_back(cyc + memLat);
      rdIdx++;
      inFl++;
    end
    if (wrReqValid && wrReqReady) begin
      if (wrReqAddr != expOut + 64 * wrIdx) begin
        wrErrs++;
        $display("mismatch wr addr %h exp %h", wrReqAddr, expOut + 64 * wrIdx);
      end
      wrIdx++;
    end
    if (wrDataValid && wrDataReady) begin
      if (!(rdRspValid && rdRspReady) || wrData != pat(expIn + 64 * datIdx)) begin
        datErrs++;
        $display("mismatch data line %0d", datIdx);
      end
      if (qa.size() > 0) begin
        void'(qa.pop_front());
        void'(qr.pop_front());
      end
      datIdx++;
      inFl--;
    end
    if (inFl > maxInFl) maxInFl = inFl;
    if (!start) begin
      rdIdx = 0; wrIdx = 0; datIdx = 0; inFl = 0; maxInFl = 0;
    end
  end

  int errors = 0, checks = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [AW-1:0] inB;
    logic [AW-1:0] outB;
    logic [CW-1:0] cnt;
    logic [7:0]    lat;
    logic [1:0]    mode;
    logic          expSat;
    logic [15:0]   maxCyc;
  } vec_t;

  localparam vec_t VECS[5] = '{
    '{48'h0000_0000_1000, 48'h0000_0008_0000, 32'd16, 8'd2,  2'd0, 1'b0, 16'd28},
    '{48'h0000_0040_0000, 48'h0000_0050_0000, 32'd40, 8'd30, 2'd0, 1'b1, 16'd0},
    '{48'h0000_0001_2340, 48'h0000_9990_0000, 32'd25, 8'd5,  2'd1, 1'b0, 16'd0},
    '{48'h0000_7000_0000, 48'h0000_7100_0000, 32'd1,  8'd3,  2'd2, 1'b0, 16'd0},
    '{48'h0001_0000_0040, 48'h0002_0000_0000, 32'd33, 8'd12, 2'd1, 1'b1, 16'd0}
  };

  task automatic runCopy(input logic [AW-1:0] inB, input logic [AW-1:0] outB,
                         input int cnt, input int lat, input int mode,
                         input bit scramble, input bit expSat, input int maxCyc);
    int n, e0, e1, e2, e3;
    e0 = rdErrs; e1 = wrErrs; e2 = datErrs; e3 = holdErrs;
    @(negedge clk);
    memLat = lat; rdyMode = mode;
    expIn = inB; expOut = outB;
    inBase = inB; outBase = outB; lineCount = cnt;
    start = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (scramble && n == 3) begin
        inBase = 48'h0000_DEAD_0000; outBase = 48'h0000_BEEF_0000; lineCount = 3;
      end
    end while (!done && n < 20000);
    #2;
    check("R7", "done reached", done, 1);
    check("R3", "read addr errors", rdErrs - e0, 0);
    check("R3", "reads issued", rdIdx, cnt);
    check("R4", "write addr errors", wrErrs - e1, 0);
    check("R4", "write reqs", wrIdx, cnt);
    check("R5", "data errors", datErrs - e2, 0);
    check("R5", "data beats", datIdx, cnt);
    check("R9", "hold errors", holdErrs - e3, 0);
    check("R6", "in-flight within budget", (maxInFl <= NS), 1);
    if (expSat) check("R6", "in-flight peak", maxInFl, NS);
    if (maxCyc > 0) check("R10", "cycles within bound", (n <= maxCyc), 1);
    if (scramble) check("R2", "line count kept", datIdx, cnt);
    repeat (4) @(negedge clk);
    #2;
    check("R7", "done held", done, 1);
    check("R7", "no requests while done", rdReqValid | wrReqValid, 0);
    start = 1'b0;
    @(negedge clk);
    #2;
    check("R7", "done cleared", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R1", "done in reset", done, 0);
    check("R1", "valids in reset", rdReqValid | wrReqValid | wrDataValid, 0);
    check("R1", "rsp ready in reset", rdRspReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check("R1", "done after reset", done, 0);
    check("R1", "valids after reset", rdReqValid | wrReqValid | wrDataValid | rdRspReady, 0);

    for (int i = 0; i < 5; i++)
      runCopy(VECS[i].inB, VECS[i].outB, int'(VECS[i].cnt), int'(VECS[i].lat),
              int'(VECS[i].mode), 1'b0, VECS[i].expSat, int'(VECS[i].maxCyc));

    // R2: config changes mid-copy ignored
    runCopy(48'h0000_0000_2000, 48'h0000_0000_3000, 10, 4, 1, 1'b1, 1'b0, 0);

    // R8: zero-length copy
    @(negedge clk);
    rdyMode = 0; expIn = '0; expOut = '0;
    lineCount = 0; inBase = 48'h100; outBase = 48'h200;
    start = 1'b1;
    @(negedge clk);
    #2;
    check("R8", "done next cycle for zero count", done, 1);
    repeat (3) @(negedge clk);
    #2;
    check("R8", "no reads", rdIdx, 0);
    check("R8", "no write reqs", wrIdx, 0);
    check("R8", "no write data", datIdx, 0);
    start = 1'b0;
    @(negedge clk);
    #2;
    check("R7", "done cleared after zero copy", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule